// File: doc/BRIEF.md
# PCM Highway Time Slot Assigner

This block sits between a set of per-channel voice sample registers and a serial time-division-multiplexed PCM highway. It follows an external bit clock and a frame sync pulse, counts bit positions within the frame, and in each 8-bit slot decides whether one of its channels owns that slot. For an owning channel it shifts the sample onto the serial transmit line and raises the output enable. It also collects the bits on the serial receive line into a per-channel receive buffer.

Each channel has its own transmit slot, its own receive slot and a sample format. A companded sample is one byte in one slot. A linear sample is 16 bits spread over two adjacent slots, high byte first. In companded mode a channel may append a signaling byte on transmit. A single setting chooses whether transmit data is launched on the rising or the falling bit clock edge. Receive data is captured on the other edge. Software loads transmit samples and reads received samples through a small parallel port.

All logic runs on a fast system clock. The bit clock, frame sync and receive data are brought into that domain through a synchronizer. Edges of the bit clock become single-cycle strobes.

Top module: `pcm_slot_assigner`

## Requirements
- R1: After reset, and until the first frame sync has been seen, `pcm_oe` and `pcm_tx` are 0. After reset every receive buffer reads 0.
- R2: A frame sync that is high at a launch edge restarts the frame. That same edge launches bit 7 of slot 0, and bits within a slot go out most significant first.
- R3: A companded channel (`ch_linear`=0) drives bits [7:0] of its transmit sample register during its assigned slot, with `pcm_oe` high for exactly those 8 bits.
- R4: A linear channel (`ch_linear`=1) drives bits [15:8] of its sample in its assigned slot and bits [7:0] in the slot that follows.
- R5: A companded channel with `ch_sig_en`=1 drives its signaling byte in the slot after its voice slot. A linear channel ignores `ch_sig_en`.
- R6: In a slot that no channel owns for transmit, `pcm_oe` is 0 and `pcm_tx` is 0.
- R7: With `cfg_tx_fall`=0, transmit bits change after rising bit clock edges and receive bits are captured at falling edges. With `cfg_tx_fall`=1 the two edges swap.
- R8: A companded channel captures its receive slot most significant bit first. It stores the byte as {8'h00, byte} in its receive buffer once the slot's last bit has been captured.
- R9: A linear channel captures two adjacent receive slots, the first as bits [15:8]. Its receive buffer keeps its old value until the last bit of the second slot has been captured.
- R10: A transmit or receive slot assignment equal to or above `cfg_slots` is ignored: that channel never drives the highway and its receive buffer never changes.
- R11: Without a new frame sync, the frame wraps to slot 0 bit 7 after `cfg_slots` slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_slots | input | SLOT_W+1 | Number of 8-bit slots per frame |
| cfg_tx_fall | input | 1 | 1: launch transmit bits on falling edges, capture on rising edges |
| ch_tx_slot | input | NUM_CH*SLOT_W | Transmit slot per channel, channel 0 in the low bits |
| ch_rx_slot | input | NUM_CH*SLOT_W | Receive slot per channel, channel 0 in the low bits |
| ch_linear | input | NUM_CH | Per-channel 16-bit linear format select |
| ch_sig_en | input | NUM_CH | Per-channel transmit signaling byte enable |
| pcm_bclk | input | 1 | Highway bit clock |
| pcm_fsync | input | 1 | Highway frame sync |
| pcm_rx | input | 1 | Highway serial receive data |
| pcm_tx | output | 1 | Highway serial transmit data |
| pcm_oe | output | 1 | Transmit output enable, high in owned slots |
| host_we | input | 1 | Write strobe for a transmit sample register |
| host_ch | input | CH_W | Channel addressed by a write |
| host_tx_data | input | 16 | Transmit sample to store |
| host_tx_sig | input | 8 | Signaling byte to store |
| host_rd_ch | input | CH_W | Channel whose receive buffer is shown |
| host_rx_data | output | 16 | Receive buffer of `host_rd_ch` |

## Verification
A bit clock transition reaches the output registers three system clocks later: two synchronizer stages, then one edge-detect stage. `pcm_tx` and `pcm_oe` therefore settle three cycles after a launch transition. A receive buffer is updated three cycles after the capture transition of its final bit. The bench holds each bit clock level for eight system clocks. It compares the transmit line seven cycles after each launch transition, just before the opposite edge, against a queue of expected values built from the slot plan. Receive buffers are read once half a bit period has passed after the last capture. One read is taken mid-frame to show that a linear buffer has not yet changed.

// File: rtl/tsa_pkg.sv
// Shared types for the time slot assigner: which byte of a channel's
// data occupies the slot currently on the highway.
package tsa_pkg;

    typedef enum logic [1:0] {
        LANE_NONE = 2'd0,
        LANE_MSB  = 2'd1,
        LANE_LSB  = 2'd2,
        LANE_SIG  = 2'd3
    } lane_e;

    // Map slot hits and channel format onto the transmit byte lane.
    function automatic lane_e lane_decode(input logic first_hit, input logic next_hit,
                                          input logic linear, input logic sig_en);
        lane_e r;
        r = LANE_NONE;
        if (first_hit)
            r = linear ? LANE_MSB : LANE_LSB;
        else if (next_hit && linear)
            r = LANE_LSB;
        else if (next_hit && sig_en)
            r = LANE_SIG;
        return r;
    endfunction

endpackage

// File: rtl/tsa_clk_sync.sv
// Brings bit clock, frame sync and receive data into the system clock
// domain and turns bit clock edges into one-cycle strobes.
// Assumes each bit clock level lasts at least STAGES+1 system clocks.
// All three inputs pass through the same number of stages, so frame sync
// and receive data are aligned with the edge that the strobes mark.
module tsa_clk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_in,
    input  logic fsync_in,
    input  logic rx_in,
    input  logic tx_fall,
    output logic launch_stb,
    output logic sample_stb,
    output logic fs_at,
    output logic rx_bit
);
    logic [STAGES:0]   bclk_q;
    logic [STAGES-1:0] fs_q;
    logic [STAGES-1:0] rx_q;
    logic              rise;
    logic              fall;

    // Shift the highway inputs through the synchronizer chains.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_q <= '0;
            fs_q   <= '0;
            rx_q   <= '0;
        end else begin
            bclk_q <= {bclk_q[STAGES-1:0], bclk_in};
            fs_q   <= {fs_q[STAGES-2:0], fsync_in};
            rx_q   <= {rx_q[STAGES-2:0], rx_in};
        end
    end

    // Detect edges and route them to launch or capture by the edge select.
    always_comb begin
        rise       = bclk_q[STAGES-1] & ~bclk_q[STAGES];
        fall       = ~bclk_q[STAGES-1] & bclk_q[STAGES];
        launch_stb = tx_fall ? fall : rise;
        sample_stb = tx_fall ? rise : fall;
        fs_at      = fs_q[STAGES-1];
        rx_bit     = rx_q[STAGES-1];
    end
endmodule

// File: rtl/tsa_frame_pos.sv
// Bit position counter within the frame. Position p is bit (7 - p%8) of
// slot p/8. It advances on each launch strobe, restarts at 0 when frame
// sync is high at a launch strobe, and wraps after cfg_slots slots.
// Assumes cfg_slots does not change while the highway runs.
module tsa_frame_pos #(
    parameter int SLOT_W = 7,
    localparam int POS_W = SLOT_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch_stb,
    input  logic              fs_at,
    input  logic [SLOT_W:0]   cfg_slots,
    output logic [POS_W-1:0]  pos,
    output logic              synced,
    output logic [POS_W-1:0]  pos_nxt,
    output logic              synced_nxt
);
    logic [POS_W:0] limit;
    logic           wrap;

    // Next position: restart on sync, wrap at the frame length, else step.
    always_comb begin
        limit      = {cfg_slots, 3'b000};
        wrap       = ({1'b0, pos} + 1'b1) >= limit;
        synced_nxt = synced | fs_at;
        if (fs_at || wrap)
            pos_nxt = '0;
        else
            pos_nxt = pos + 1'b1;
    end

    // Commit the position at every launch strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos    <= '0;
            synced <= 1'b0;
        end else if (launch_stb) begin
            pos    <= pos_nxt;
            synced <= synced_nxt;
        end
    end
endmodule

// File: rtl/tsa_tx_path.sv
// Transmit side: for the position about to be launched, find the channel
// that owns the slot, pick its byte lane and bit, and register the bit and
// the output enable at the launch strobe. If assignments overlap, the
// lowest numbered channel wins.
module tsa_tx_path
    import tsa_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int SLOT_W = 7,
    localparam int POS_W = SLOT_W + 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     launch_stb,
    input  logic                     synced_nxt,
    input  logic [POS_W-1:0]         pos_nxt,
    input  logic [SLOT_W:0]          cfg_slots,
    input  logic [NUM_CH*SLOT_W-1:0] tx_slot,
    input  logic [NUM_CH-1:0]        linear,
    input  logic [NUM_CH-1:0]        sig_en,
    input  logic [NUM_CH*16-1:0]     tx_data,
    input  logic [NUM_CH*8-1:0]      tx_sig,
    output logic                     pcm_tx,
    output logic                     pcm_oe
);
    logic [SLOT_W-1:0] slot;
    logic [2:0]        bsel;
    logic [NUM_CH-1:0] ch_act;
    logic [NUM_CH-1:0] ch_bit;
    logic              pick_act;
    logic              pick_bit;

    assign slot = pos_nxt[POS_W-1:3];
    assign bsel = ~pos_nxt[2:0];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [SLOT_W-1:0] asg;
        logic              in_frame;
        logic              hit0;
        logic              hit1;
        lane_e             lane;
        logic [7:0]        byte_v;

        // Decode slot ownership and the byte this channel offers.
        always_comb begin
            asg      = tx_slot[c*SLOT_W +: SLOT_W];
            in_frame = {1'b0, asg} < cfg_slots;
            hit0     = in_frame && (slot == asg);
            hit1     = in_frame && ({1'b0, slot} == ({1'b0, asg} + 1'b1));
            lane     = lane_decode(hit0, hit1, linear[c], sig_en[c]);
            case (lane)
                LANE_MSB: byte_v = tx_data[c*16+8 +: 8];
                LANE_LSB: byte_v = tx_data[c*16 +: 8];
                LANE_SIG: byte_v = tx_sig[c*8 +: 8];
                default:  byte_v = 8'h00;
            endcase
            ch_act[c] = (lane != LANE_NONE);
            ch_bit[c] = byte_v[bsel];
        end
    end

    // Priority pick: scan downward so the lowest active channel remains.
    always_comb begin
        pick_act = 1'b0;
        pick_bit = 1'b0;
        for (int c = NUM_CH - 1; c >= 0; c--) begin
            if (ch_act[c]) begin
                pick_act = 1'b1;
                pick_bit = ch_bit[c];
            end
        end
    end

    // Launch the chosen bit and the enable on the selected edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcm_tx <= 1'b0;
            pcm_oe <= 1'b0;
        end else if (launch_stb) begin
            pcm_oe <= pick_act & synced_nxt;
            pcm_tx <= pick_bit & pick_act & synced_nxt;
        end
    end
endmodule

// File: rtl/tsa_rx_path.sv
// Receive side: each channel shifts in the bits of its own receive slot
// (two slots when linear) at capture strobes. It copies the assembled
// sample into its buffer only when the last bit of its last slot has
// arrived. Receive has no signaling byte.
module tsa_rx_path #(
    parameter int NUM_CH = 4,
    parameter int SLOT_W = 7,
    localparam int POS_W = SLOT_W + 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sample_stb,
    input  logic                     synced,
    input  logic [POS_W-1:0]         pos,
    input  logic                     rx_bit,
    input  logic [SLOT_W:0]          cfg_slots,
    input  logic [NUM_CH*SLOT_W-1:0] rx_slot,
    input  logic [NUM_CH-1:0]        linear,
    output logic [NUM_CH*16-1:0]     rx_buf
);
    logic [SLOT_W-1:0] slot;
    logic              last_bit;

    assign slot     = pos[POS_W-1:3];
    assign last_bit = (pos[2:0] == 3'd7);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [SLOT_W-1:0] asg;
        logic              in_frame;
        logic              hit0;
        logic              hit1;
        logic              take;
        logic              finish;
        logic [15:0]       sh;
        logic [15:0]       hold;

        // Decide whether this capture belongs to the channel and ends it.
        always_comb begin
            asg      = rx_slot[c*SLOT_W +: SLOT_W];
            in_frame = {1'b0, asg} < cfg_slots;
            hit0     = in_frame && (slot == asg);
            hit1     = in_frame && ({1'b0, slot} == ({1'b0, asg} + 1'b1));
            take     = sample_stb && synced && (hit0 || (hit1 && linear[c]));
            finish   = take && last_bit && (linear[c] ? hit1 : hit0);
        end

        // Collect incoming bits most significant first.
        always_ff @(posedge clk) begin
            if (!rst_n)
                sh <= '0;
            else if (take)
                sh <= {sh[14:0], rx_bit};
        end

        // Publish the completed sample once its final bit is in.
        always_ff @(posedge clk) begin
            if (!rst_n)
                hold <= '0;
            else if (finish)
                hold <= linear[c] ? {sh[14:0], rx_bit} : {8'h00, sh[6:0], rx_bit};
        end

        assign rx_buf[c*16 +: 16] = hold;
    end
endmodule

// File: rtl/pcm_slot_assigner.sv
// Top of the PCM highway time slot assigner. It holds the transmit sample
// registers written from the parallel port and wires the synchronizer,
// frame counter, transmit path and receive path together.
// Assumes the system clock runs at least six times faster than the bit
// clock and that configuration is held steady while the highway runs.
module pcm_slot_assigner #(
    parameter int NUM_CH  = 4,
    parameter int SLOT_W  = 7,
    parameter int STAGES  = 2,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int POS_W  = SLOT_W + 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [SLOT_W:0]          cfg_slots,
    input  logic                     cfg_tx_fall,
    input  logic [NUM_CH*SLOT_W-1:0] ch_tx_slot,
    input  logic [NUM_CH*SLOT_W-1:0] ch_rx_slot,
    input  logic [NUM_CH-1:0]        ch_linear,
    input  logic [NUM_CH-1:0]        ch_sig_en,
    input  logic                     pcm_bclk,
    input  logic                     pcm_fsync,
    input  logic                     pcm_rx,
    output logic                     pcm_tx,
    output logic                     pcm_oe,
    input  logic                     host_we,
    input  logic [CH_W-1:0]          host_ch,
    input  logic [15:0]              host_tx_data,
    input  logic [7:0]               host_tx_sig,
    input  logic [CH_W-1:0]          host_rd_ch,
    output logic [15:0]              host_rx_data
);
    logic                 launch_stb;
    logic                 sample_stb;
    logic                 fs_at;
    logic                 rx_bit;
    logic [POS_W-1:0]     pos;
    logic [POS_W-1:0]     pos_nxt;
    logic                 synced;
    logic                 synced_nxt;
    logic [NUM_CH*16-1:0] tx_data_q;
    logic [NUM_CH*8-1:0]  tx_sig_q;
    logic [NUM_CH*16-1:0] rx_buf;

    // Store transmit samples and signaling bytes from the parallel port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_data_q <= '0;
            tx_sig_q  <= '0;
        end else if (host_we && (int'(host_ch) < NUM_CH)) begin
            tx_data_q[host_ch*16 +: 16] <= host_tx_data;
            tx_sig_q[host_ch*8 +: 8]    <= host_tx_sig;
        end
    end

    // Present the selected channel's receive buffer.
    always_comb begin
        host_rx_data = 16'h0000;
        if (int'(host_rd_ch) < NUM_CH)
            host_rx_data = rx_buf[host_rd_ch*16 +: 16];
    end

    tsa_clk_sync #(.STAGES(STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .bclk_in    (pcm_bclk),
        .fsync_in   (pcm_fsync),
        .rx_in      (pcm_rx),
        .tx_fall    (cfg_tx_fall),
        .launch_stb (launch_stb),
        .sample_stb (sample_stb),
        .fs_at      (fs_at),
        .rx_bit     (rx_bit)
    );

    tsa_frame_pos #(.SLOT_W(SLOT_W)) u_pos (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch_stb (launch_stb),
        .fs_at      (fs_at),
        .cfg_slots  (cfg_slots),
        .pos        (pos),
        .synced     (synced),
        .pos_nxt    (pos_nxt),
        .synced_nxt (synced_nxt)
    );

    tsa_tx_path #(.NUM_CH(NUM_CH), .SLOT_W(SLOT_W)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch_stb (launch_stb),
        .synced_nxt (synced_nxt),
        .pos_nxt    (pos_nxt),
        .cfg_slots  (cfg_slots),
        .tx_slot    (ch_tx_slot),
        .linear     (ch_linear),
        .sig_en     (ch_sig_en),
        .tx_data    (tx_data_q),
        .tx_sig     (tx_sig_q),
        .pcm_tx     (pcm_tx),
        .pcm_oe     (pcm_oe)
    );

    tsa_rx_path #(.NUM_CH(NUM_CH), .SLOT_W(SLOT_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_stb (sample_stb),
        .synced     (synced),
        .pos        (pos),
        .rx_bit     (rx_bit),
        .cfg_slots  (cfg_slots),
        .rx_slot    (ch_rx_slot),
        .linear     (ch_linear),
        .rx_buf     (rx_buf)
    );
endmodule

// File: rtl/tsa_checker.sv
// Protocol assertions for pcm_slot_assigner, attached by bind below.
// Assumes cfg_slots and cfg_tx_fall only change while reset is held.
module tsa_checker #(
    parameter int SLOT_W = 7,
    localparam int POS_W = SLOT_W + 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             launch_stb,
    input logic             sample_stb,
    input logic             fs_at,
    input logic [POS_W-1:0] pos,
    input logic             synced,
    input logic [SLOT_W:0]  cfg_slots,
    input logic             pcm_tx,
    input logic             pcm_oe
);
    // R7: launch and capture come from opposite edges, never together.
    a_r7_edges_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(launch_stb && sample_stb));

    // R7: the highway outputs only move right after a launch strobe.
    a_r7_out_moves_on_launch: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({pcm_oe, pcm_tx}) |-> $past(launch_stb));

    // R2: frame sync at a launch edge puts the counter at slot 0 bit 7.
    a_r2_sync_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_stb && fs_at) |=> ((pos == '0) && synced));

    // R11: after any launch the position lies inside the configured frame.
    a_r11_pos_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        launch_stb |=> ({1'b0, pos} < {cfg_slots, 3'b000}));

    // R1: nothing is driven before the first frame sync.
    a_r1_quiet_unsynced: assert property (@(posedge clk) disable iff (!rst_n)
        !synced |-> !pcm_oe);
endmodule

bind pcm_slot_assigner tsa_checker #(.SLOT_W(SLOT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .launch_stb (launch_stb),
    .sample_stb (sample_stb),
    .fs_at      (fs_at),
    .pos        (pos),
    .synced     (synced),
    .cfg_slots  (cfg_slots),
    .pcm_tx     (pcm_tx),
    .pcm_oe     (pcm_oe)
);

// File: tb/sim_pcm_slot_assigner.sv
// Scoreboard bench: the driver walks the bit clock through whole frames
// and queues the expected transmit bit for every position. The monitor
// pops and compares at each sample point. Receive buffers are checked
// through the parallel port.
module sim_pcm_slot_assigner;
    localparam int NUM_CH = 4;
    localparam int SLOT_W = 7;
    localparam int HALF   = 8;
    localparam int SLOTS  = 8;

    logic                     clk = 1'b0;
    logic                     rst_n;
    logic [SLOT_W:0]          cfg_slots;
    logic                     cfg_tx_fall;
    logic [NUM_CH*SLOT_W-1:0] ch_tx_slot;
    logic [NUM_CH*SLOT_W-1:0] ch_rx_slot;
    logic [NUM_CH-1:0]        ch_linear;
    logic [NUM_CH-1:0]        ch_sig_en;
    logic                     pcm_bclk;
    logic                     pcm_fsync;
    logic                     pcm_rx;
    logic                     pcm_tx;
    logic                     pcm_oe;
    logic                     host_we;
    logic [1:0]               host_ch;
    logic [15:0]              host_tx_data;
    logic [7:0]               host_tx_sig;
    logic [1:0]               host_rd_ch;
    logic [15:0]              host_rx_data;

    int         n_chk  = 0;
    int         n_fail = 0;
    logic       launch_lvl;
    int         tsl [NUM_CH] = '{1, 3, 6, 9};
    int         rsl [NUM_CH] = '{2, 4, 0, 12};
    logic [15:0] tx_d [NUM_CH];
    logic [7:0]  tx_s [NUM_CH];
    logic [7:0]  rx_pat [SLOTS];
    logic [1:0] exp_q [$];
    string      tag_q [$];
    event       smp_ev;

    always #5 clk = ~clk;

    pcm_slot_assigner u0 (
        .clk(clk), .rst_n(rst_n), .cfg_slots(cfg_slots), .cfg_tx_fall(cfg_tx_fall),
        .ch_tx_slot(ch_tx_slot), .ch_rx_slot(ch_rx_slot), .ch_linear(ch_linear),
        .ch_sig_en(ch_sig_en), .pcm_bclk(pcm_bclk), .pcm_fsync(pcm_fsync),
        .pcm_rx(pcm_rx), .pcm_tx(pcm_tx), .pcm_oe(pcm_oe), .host_we(host_we),
        .host_ch(host_ch), .host_tx_data(host_tx_data), .host_tx_sig(host_tx_sig),
        .host_rd_ch(host_rd_ch), .host_rx_data(host_rx_data)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected highway output for frame position p, from the slot plan.
    function automatic void model(input int p, output logic [1:0] e, output string t);
        int slot = p / 8;
        int b = 7 - (p % 8);
        logic [7:0] v;
        e = 2'b00;
        t = "R6";
        for (int c = NUM_CH - 1; c >= 0; c--) begin
            if (tsl[c] < SLOTS) begin
                if (slot == tsl[c]) begin
                    v = ch_linear[c] ? tx_d[c][15:8] : tx_d[c][7:0];
                    e = {1'b1, v[b]};
                    t = ch_linear[c] ? "R4" : "R3";
                end else if (slot == tsl[c] + 1 && ch_linear[c]) begin
                    v = tx_d[c][7:0];
                    e = {1'b1, v[b]};
                    t = "R4";
                end else if (slot == tsl[c] + 1 && ch_sig_en[c]) begin
                    v = tx_s[c];
                    e = {1'b1, v[b]};
                    t = "R5";
                end
            end
        end
    endfunction

    // Monitor: compare the highway outputs with the head of the queue.
    always @(smp_ev) begin
        logic [1:0] e;
        string t;
        if (exp_q.size() == 0) begin
            check("R3 scoreboard empty", 16'h0001, 16'h0000);
        end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, {14'b0, pcm_oe, pcm_tx}, {14'b0, e});
        end
    end

    task automatic host_write(input int c, input logic [15:0] d, input logic [7:0] s);
        host_we = 1'b1; host_ch = 2'(c); host_tx_data = d; host_tx_sig = s;
        tx_d[c] = d; tx_s[c] = s;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic bit_period(input logic fs, input logic rxb);
        pcm_bclk = launch_lvl; pcm_fsync = fs; pcm_rx = rxb;
        repeat (HALF - 1) @(negedge clk);
        -> smp_ev;
        @(negedge clk);
        pcm_bclk = ~launch_lvl;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic run_frame(input logic with_fs, input string over, input logic [15:0] mid_exp);
        logic [1:0] e;
        string t;
        host_rd_ch = 2'd1;
        for (int p = 0; p < SLOTS * 8; p++) begin
            model(p, e, t);
            if (p == 0) t = with_fs ? "R2" : "R11";
            if (over != "") t = over;
            exp_q.push_back(e);
            tag_q.push_back(t);
            bit_period(with_fs && (p == 0), rx_pat[p / 8][7 - (p % 8)]);
            // R9: linear buffer unchanged while its second slot is in flight
            if (p == 43) check("R9 mid-frame hold", host_rx_data, mid_exp);
        end
    endtask

    task automatic read_rx(input int c, output logic [15:0] v);
        host_rd_ch = 2'(c);
        @(negedge clk);
        v = host_rx_data;
    endtask

    task automatic check_rx_all();
        logic [15:0] v;
        read_rx(0, v); check("R8 companded rx ch0", v, {8'h00, rx_pat[2]});
        read_rx(1, v); check("R9 linear rx ch1", v, {rx_pat[4], rx_pat[5]});
        read_rx(2, v); check("R8 companded rx ch2", v, {8'h00, rx_pat[0]});
        read_rx(3, v); check("R10 out-of-frame rx ch3", v, 16'h0000);
    endtask

    task automatic check_reset();
        logic [15:0] v;
        check("R1 oe after reset", {15'b0, pcm_oe}, 16'h0000);
        check("R1 tx after reset", {15'b0, pcm_tx}, 16'h0000);
        for (int c = 0; c < NUM_CH; c++) begin
            read_rx(c, v);
            check("R1 rx buffer after reset", v, 16'h0000);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired R1 actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_slots = 8'(SLOTS); cfg_tx_fall = 1'b0; launch_lvl = 1'b1;
        ch_tx_slot = {7'd9, 7'd6, 7'd3, 7'd1};
        ch_rx_slot = {7'd12, 7'd0, 7'd4, 7'd2};
        ch_linear = 4'b0010;
        ch_sig_en = 4'b1110;
        pcm_bclk = 1'b0; pcm_fsync = 1'b0; pcm_rx = 1'b0;
        host_we = 1'b0; host_ch = 2'd0; host_tx_data = 16'h0; host_tx_sig = 8'h0;
        host_rd_ch = 2'd0;
        for (int c = 0; c < NUM_CH; c++) begin tx_d[c] = 16'h0; tx_s[c] = 8'h0; end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_reset();

        // Frame 1: rising-edge launch, frame sync present.
        host_write(0, 16'h00B6, 8'h00);
        host_write(1, 16'hC35A, 8'hFF);
        host_write(2, 16'h0071, 8'h8E);
        host_write(3, 16'hFFFF, 8'hFF);
        rx_pat = '{8'hA5, 8'h11, 8'hC3, 8'h22, 8'h9E, 8'h47, 8'h33, 8'h44};
        run_frame(1'b1, "", 16'h0000);
        check_rx_all();

        // Frame 2: no frame sync, counter must wrap by itself (R11).
        host_write(0, 16'h0049, 8'h00);
        host_write(1, 16'h1E87, 8'h00);
        host_write(2, 16'h00D2, 8'h35);
        rx_pat = '{8'h5A, 8'h0F, 8'h3C, 8'hF0, 8'h61, 8'hB8, 8'h77, 8'h88};
        run_frame(1'b0, "", 16'h9E47);
        check_rx_all();

        // Reset, then falling-edge launch (R7).
        rst_n = 1'b0; cfg_tx_fall = 1'b1; launch_lvl = 1'b0; pcm_bclk = 1'b1;
        for (int c = 0; c < NUM_CH; c++) begin tx_d[c] = 16'h0; tx_s[c] = 8'h0; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_reset();
        host_write(0, 16'h00E1, 8'h00);
        host_write(1, 16'h7C0F, 8'h00);
        host_write(2, 16'h0019, 8'hC4);
        host_write(3, 16'hAAAA, 8'h55);
        // R1: bit clock runs but no frame sync yet, so nothing is driven.
        for (int i = 0; i < 3; i++) begin
            exp_q.push_back(2'b00);
            tag_q.push_back("R1");
            bit_period(1'b0, 1'b1);
        end
        rx_pat = '{8'h6D, 8'h00, 8'h92, 8'hFF, 8'h2B, 8'hD4, 8'h01, 8'h80};
        run_frame(1'b1, "R7", 16'h0000);
        check_rx_all();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule